// File: doc/BRIEF.md
# I2S to Latched-Serial DAC Formatter

This block takes a stereo I2S stream whose bit clock, word select and data are already synchronous to the local master clock. It re-emits each sample as a right-justified word for a multibit DAC that loads through a serial shift register and then transfers on a latch strobe. The outputs are a gated bit clock at half the master clock, one serial data line per channel, and a separate latch strobe per channel.

Each stereo frame is captured completely before its output begins. The left word is sent first and the right word second, so output lags input by one frame. Three static inputs set the output shape: a width code, a stopped-clock mode, and an option that adds four trailing clocks after each latch for DACs that need them. Surplus input LSBs are dropped when a short width is chosen.

Top module: `lsdac_fmt`

## Requirements
- R1: `cfg_width` selects the output word length: code 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The word sent is the top bits of the 24 most significant received bits.
- R2: Each word goes out MSB first and is right-justified. The last W rising edges of `dac_bck` before a latch falling edge carry the W-bit word, and its LSB is the final one.
- R3: `dac_bck` is high for exactly one master-clock cycle at a time, so it runs at half the master clock. The data lines change only while `dac_bck` is low.
- R4: A latch strobe rises before the third-from-last bit of its word and stays high across exactly three `dac_bck` rising edges before it falls.
- R5: With `cfg_stop` set, the clock stops after the LSB. The latch falls three master cycles after the LSB rising edge, with `dac_bck` low throughout. With `cfg_stop` clear, the latch falls one cycle after that edge.
- R6: With `cfg_tail` set, exactly four `dac_bck` pulses follow each latch falling edge before the next word begins. With it clear, the next word follows at once. Between the left latch falling and the right latch rising there are therefore 4·tail + W − 3 pulses.
- R7: The left word appears only on `dac_dl` and goes with `dac_le_l`. The right word appears only on `dac_dr` and goes with `dac_le_r`. The two strobes are never high together, and the idle data line stays low while the other channel's strobe is high.
- R8: Input convention: `i2s_ws` low marks the left channel, and the MSB arrives one bit clock after a `i2s_ws` change. Data is taken on the `i2s_bck` rising edge. The bit taken on the rising edge where `i2s_ws` changes belongs to the previous word.
- R9: A pair is output only after both of its channels have been received. The left word is latched before the right word of the same frame.
- R10: While reset is held, `dac_bck`, `dac_le_l` and `dac_le_r` are low. No `dac_bck` pulse appears before a complete frame has been received.
- R11: With frames arriving back to back every 128 master cycles, every frame is delivered in every configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| i2s_bck | input | 1 | I2S bit clock, synchronous to clk |
| i2s_ws | input | 1 | I2S word select, low = left |
| i2s_sd | input | 1 | I2S serial data |
| cfg_width | input | 2 | Output word length code |
| cfg_stop | input | 1 | Stopped-clock mode |
| cfg_tail | input | 1 | Four trailing clocks after each latch |
| dac_bck | output | 1 | Gated output bit clock |
| dac_dl | output | 1 | Left channel serial data |
| dac_dr | output | 1 | Right channel serial data |
| dac_le_l | output | 1 | Left latch strobe |
| dac_le_r | output | 1 | Right latch strobe |

## Verification
With stopped-clock mode and the trailing clocks both off, two events share a single master cycle: the left latch falls, and the first bit of the right word is placed on the bus. The sweep over all sixteen width, stop and tail settings includes these cases. There the bench confirms that the left word still arrives intact, that the pulse count between the left latch falling and the right latch rising is exactly W − 3, and that the right lane stays low while the left strobe is high. The same count with tails enabled shows that the four extra pulses slot in between the two words without disturbing either one.

// File: rtl/lsdac_pkg.sv
`timescale 1ns/1ps
package lsdac_pkg;
    localparam int SAMPLE_W  = 24;
    localparam int LE_LEAD   = 3;
    localparam int TAIL_CLKS = 4;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_DATA,
        SER_HOLD,
        SER_TAIL
    } ser_state_e;

    function automatic int word_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction
endpackage

// File: rtl/lsdac_i2s_rx.sv
`timescale 1ns/1ps
module lsdac_i2s_rx
    import lsdac_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bck_i,
    input  logic    ws_i,
    input  logic    sd_i,
    output logic    frame_vld,
    output stereo_t frame
);
    localparam int CW = $clog2(SW + 1);

    logic          bck_q;
    logic          ws_last;
    logic          started;
    logic          have_left;
    logic [CW-1:0] cnt;
    logic [SW-1:0] sr;
    logic [SW-1:0] lbuf;
    logic          rise;

    assign rise = bck_i & ~bck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_q     <= 1'b0;
            ws_last   <= 1'b0;
            started   <= 1'b0;
            have_left <= 1'b0;
            cnt       <= '0;
            sr        <= '0;
            lbuf      <= '0;
            frame     <= '0;
            frame_vld <= 1'b0;
        end else begin
            bck_q     <= bck_i;
            frame_vld <= 1'b0;
            if (rise) begin
                if (ws_i != ws_last) begin
                    ws_last <= ws_i;
                    started <= 1'b1;
                    cnt     <= '0;
                    sr      <= '0;
                    if (started) begin
                        if (!ws_last) begin
                            lbuf      <= sr;
                            have_left <= 1'b1;
                        end else if (have_left) begin
                            frame.left  <= lbuf;
                            frame.right <= sr;
                            frame_vld   <= 1'b1;
                            have_left   <= 1'b0;
                        end
                    end
                end else if (cnt < CW'(SW)) begin
                    sr  <= {sr[SW-2:0], sd_i};
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lsdac_serializer.sv
`timescale 1ns/1ps
module lsdac_serializer
    import lsdac_pkg::*;
#(
    parameter int SW     = SAMPLE_W,
    parameter int LEAD   = LE_LEAD,
    parameter int TAIL_N = TAIL_CLKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_vld,
    input  stereo_t    start_pair,
    input  logic [1:0] cfg_width,
    input  logic       cfg_stop,
    input  logic       cfg_tail,
    output logic       take,
    output logic       bck_o,
    output logic       dl_o,
    output logic       dr_o,
    output logic       le_l_o,
    output logic       le_r_o
);
    localparam int CW = $clog2(SW + 1);

    ser_state_e    state, nxt;
    logic          ph;
    logic          ch;
    logic [CW-1:0] cnt;
    logic [CW-1:0] wlen;
    logic [SW-1:0] sr;
    logic [SW-1:0] rword;
    logic          stop_q, tail_q;
    logic          last_bit, word_done, le_on;

    assign last_bit = (cnt == wlen - 1'b1);
    assign take     = (state == SER_IDLE) && start_vld;

    always_comb begin
        nxt       = state;
        word_done = 1'b0;
        case (state)
            SER_DATA: if (last_bit) begin
                if (stop_q)      nxt = SER_HOLD;
                else if (tail_q) nxt = SER_TAIL;
                else             word_done = 1'b1;
            end
            SER_HOLD: begin
                if (tail_q) nxt = SER_TAIL;
                else        word_done = 1'b1;
            end
            SER_TAIL: if (cnt == CW'(TAIL_N - 1)) word_done = 1'b1;
            default: ;
        endcase
        if (word_done) nxt = ch ? SER_IDLE : SER_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SER_IDLE;
            ph     <= 1'b0;
            ch     <= 1'b0;
            cnt    <= '0;
            wlen   <= CW'(16);
            sr     <= '0;
            rword  <= '0;
            stop_q <= 1'b0;
            tail_q <= 1'b0;
        end else if (state == SER_IDLE) begin
            ph <= 1'b0;
            if (start_vld) begin
                sr     <= start_pair.left;
                rword  <= start_pair.right;
                wlen   <= CW'(word_len(cfg_width));
                stop_q <= cfg_stop;
                tail_q <= cfg_tail;
                ch     <= 1'b0;
                cnt    <= '0;
                state  <= SER_DATA;
            end
        end else begin
            ph <= ~ph;
            if (ph) begin
                state <= nxt;
                if (nxt != state || word_done) cnt <= '0;
                else                           cnt <= cnt + 1'b1;
                if (state == SER_DATA && !last_bit) sr <= sr << 1;
                if (word_done && !ch) begin
                    ch <= 1'b1;
                    sr <= rword;
                end
            end
        end
    end

    assign le_on  = (state == SER_DATA && cnt >= wlen - CW'(LEAD)) || (state == SER_HOLD);
    assign bck_o  = ph && (state == SER_DATA || state == SER_TAIL);
    assign dl_o   = (state == SER_DATA) && !ch && sr[SW-1];
    assign dr_o   = (state == SER_DATA) &&  ch && sr[SW-1];
    assign le_l_o = le_on && !ch;
    assign le_r_o = le_on &&  ch;
endmodule

// File: rtl/lsdac_fmt.sv
`timescale 1ns/1ps
module lsdac_fmt
    import lsdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       i2s_bck,
    input  logic       i2s_ws,
    input  logic       i2s_sd,
    input  logic [1:0] cfg_width,
    input  logic       cfg_stop,
    input  logic       cfg_tail,
    output logic       dac_bck,
    output logic       dac_dl,
    output logic       dac_dr,
    output logic       dac_le_l,
    output logic       dac_le_r
);
    logic    rx_vld;
    stereo_t rx_frame;
    logic    pend_vld;
    stereo_t pend;
    logic    take;

    lsdac_i2s_rx #(.SW(SAMPLE_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .bck_i     (i2s_bck),
        .ws_i      (i2s_ws),
        .sd_i      (i2s_sd),
        .frame_vld (rx_vld),
        .frame     (rx_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            pend     <= '0;
        end else begin
            if (take) pend_vld <= 1'b0;
            if (rx_vld) begin
                pend_vld <= 1'b1;
                pend     <= rx_frame;
            end
        end
    end

    lsdac_serializer #(.SW(SAMPLE_W), .LEAD(LE_LEAD), .TAIL_N(TAIL_CLKS)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .start_vld  (pend_vld),
        .start_pair (pend),
        .cfg_width  (cfg_width),
        .cfg_stop   (cfg_stop),
        .cfg_tail   (cfg_tail),
        .take       (take),
        .bck_o      (dac_bck),
        .dl_o       (dac_dl),
        .dr_o       (dac_dr),
        .le_l_o     (dac_le_l),
        .le_r_o     (dac_le_r)
    );
endmodule

// File: rtl/lsdac_checker.sv
`timescale 1ns/1ps
module lsdac_checker (
    input logic clk,
    input logic rst,
    input logic cfg_stop,
    input logic dac_bck,
    input logic dac_dl,
    input logic dac_dr,
    input logic dac_le_l,
    input logic dac_le_r
);
    assert_clk_half_R3: assert property (@(posedge clk) disable iff (rst)
        dac_bck |=> !dac_bck);

    assert_data_steady_R3: assert property (@(posedge clk) disable iff (rst)
        dac_bck |-> ($stable(dac_dl) && $stable(dac_dr)));

    assert_single_latch_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dac_le_l, dac_le_r}));

    assert_lane_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (dac_le_l |-> !dac_dr) and (dac_le_r |-> !dac_dl));

    assert_lead_left_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_le_l) |-> ($past(dac_le_l, 2) && $past(dac_le_l, 5)));

    assert_lead_right_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_le_r) |-> ($past(dac_le_r, 2) && $past(dac_le_r, 5)));

    assert_stop_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_stop && ($fell(dac_le_l) || $fell(dac_le_r))) |-> (!dac_bck && !$past(dac_bck)));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!dac_bck && !dac_le_l && !dac_le_r));
endmodule

bind lsdac_fmt lsdac_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_stop (cfg_stop),
    .dac_bck  (dac_bck),
    .dac_dl   (dac_dl),
    .dac_dr   (dac_dr),
    .dac_le_l (dac_le_l),
    .dac_le_r (dac_le_r)
);

// File: tb/tb_lsdac_fmt.sv
`timescale 1ns/1ps
module tb_lsdac_fmt;
    localparam int NF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       i2s_bck = 1'b0, i2s_ws = 1'b1, i2s_sd = 1'b0;
    logic [1:0] cfg_width = 2'd0;
    logic       cfg_stop = 1'b0, cfg_tail = 1'b0;
    logic       dac_bck, dac_dl, dac_dr, dac_le_l, dac_le_r;

    always #4 clk = ~clk;

    lsdac_fmt dut (
        .clk(clk), .rst(rst), .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
        .cfg_width(cfg_width), .cfg_stop(cfg_stop), .cfg_tail(cfg_tail),
        .dac_bck(dac_bck), .dac_dl(dac_dl), .dac_dr(dac_dr),
        .dac_le_l(dac_le_l), .dac_le_r(dac_le_r)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] pattern(input int f, input int ch, input int cfg);
        if (f == 0) return (ch == 0) ? 24'hFFFFFF : 24'h000000;
        return 24'(((f + 3) * 32'h8A53C1) ^ (ch * 32'h5F0F33) ^ (cfg * 32'h1357));
    endfunction

    logic [23:0] exp_l [NF];
    logic [23:0] exp_r [NF];
    int  W = 16;
    int  lefts_begun = 0;

    // monitor state
    bit          p_bck, p_ll, p_lr, seen_pulse, gap_on;
    logic [23:0] acc_l, acc_r;
    int          ptr_l, ptr_r, hl_l, hl_r, since_rise, gap_cnt;

    always @(negedge clk) begin
        if (!rst) begin
            if (dac_bck && !p_bck) begin
                acc_l = {acc_l[22:0], dac_dl};
                acc_r = {acc_r[22:0], dac_dr};
                since_rise = 0;
                if (dac_le_l) hl_l++;
                if (dac_le_r) hl_r++;
                if (gap_on) gap_cnt++;
                if (!seen_pulse) begin
                    seen_pulse = 1;
                    chk(lefts_begun >= 2, "R10/R9 first pulse before full frame", lefts_begun, 2);
                end
            end else begin
                since_rise++;
            end
            if (p_ll && !dac_le_l) begin
                if (ptr_l < NF)
                    chk((acc_l & ((24'h1 << W) - 1)) == (exp_l[ptr_l] >> (24 - W)),
                        "R1/R2 left word", acc_l & ((24'h1 << W) - 1), exp_l[ptr_l] >> (24 - W));
                chk(hl_l == 3, "R4 left latch lead pulses", hl_l, 3);
                chk(since_rise == (cfg_stop ? 3 : 1), "R5 left latch fall timing", since_rise, cfg_stop ? 3 : 1);
                hl_l = 0; ptr_l++; gap_on = 1; gap_cnt = 0;
            end
            if (!p_lr && dac_le_r && gap_on) begin
                chk(gap_cnt == 4 * cfg_tail + W - 3, "R6 pulses between left fall and right rise",
                    gap_cnt, 4 * cfg_tail + W - 3);
                gap_on = 0;
            end
            if (p_lr && !dac_le_r) begin
                if (ptr_r < NF)
                    chk((acc_r & ((24'h1 << W) - 1)) == (exp_r[ptr_r] >> (24 - W)),
                        "R7/R2 right word", acc_r & ((24'h1 << W) - 1), exp_r[ptr_r] >> (24 - W));
                chk(hl_r == 3, "R4 right latch lead pulses", hl_r, 3);
                chk(since_rise == (cfg_stop ? 3 : 1), "R5 right latch fall timing", since_rise, cfg_stop ? 3 : 1);
                chk(ptr_l == ptr_r + 1, "R9 left latched before right", ptr_l, ptr_r + 1);
                hl_r = 0; ptr_r++;
            end
            p_bck = dac_bck; p_ll = dac_le_l; p_lr = dac_le_r;
        end
    end

    task automatic period(input logic ws, input logic sd);
        @(negedge clk);
        i2s_bck = 1'b0; i2s_ws = ws; i2s_sd = sd;
        @(negedge clk);
        i2s_bck = 1'b1;
    endtask

    // R8: MSB one bit clock after the word-select change, junk after bit 24
    task automatic slot(input logic ch, input logic [23:0] word);
        for (int j = 0; j < 32; j++) begin
            if (j == 0)       period(ch, ~ch);
            else if (j <= 24) period(ch, word[24 - j]);
            else              period(ch, logic'(j[0]) ^ ch);
            if (j == 0 && ch == 1'b0) lefts_begun++;
        end
    endtask

    task automatic run(input int cfg);
        rst = 1'b1;
        cfg_width = cfg[1:0]; cfg_stop = cfg[2]; cfg_tail = cfg[3];
        W = lsdac_pkg::word_len(cfg_width);
        i2s_bck = 1'b0; i2s_ws = 1'b1; i2s_sd = 1'b0;
        lefts_begun = 0;
        p_bck = 0; p_ll = 0; p_lr = 0; seen_pulse = 0; gap_on = 0;
        acc_l = '0; acc_r = '0; ptr_l = 0; ptr_r = 0; hl_l = 0; hl_r = 0;
        since_rise = 0; gap_cnt = 0;
        for (int f = 0; f < NF; f++) begin
            exp_l[f] = pattern(f, 0, cfg);
            exp_r[f] = pattern(f, 1, cfg);
        end
        repeat (3) @(negedge clk);
        chk(!dac_bck && !dac_le_l && !dac_le_r, "R10 reset outputs low",
            {dac_bck, dac_le_l, dac_le_r}, 0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) period(1'b1, 1'b0);
        for (int f = 0; f < NF; f++) begin
            slot(1'b0, exp_l[f]);
            slot(1'b1, exp_r[f]);
        end
        slot(1'b0, 24'h0);
        repeat (200) @(negedge clk);
        chk(ptr_l == NF, "R11 all left words delivered", ptr_l, NF);
        chk(ptr_r == NF, "R11 all right words delivered", ptr_r, NF);
    endtask

    initial begin
        for (int c = 0; c < 16; c++) run(c);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule